// File: doc/BRIEF.md
# ATA Task-File Register Block

This block is the device-side register file of a parallel ATA target. The host reaches it through two chip selects, a 3-bit offset and single-cycle read and write strobes. One chip select opens the eight command-block offsets (16-bit data port, error/features, sector count, sector number, cylinder low and high, device/head, command/status). The other opens the control offset, which reads as alternate status and is written as device control. Every register except the data port uses only the low eight data lines.

An internal command engine sits behind the block. A write to the command offset raises BSY and issues a one-cycle command strobe with the opcode and features byte. The engine then either signals that it is ready for the first data sector or signals completion, with an error flag, an error code and a count of sectors left. From these the block keeps BSY, DRQ, ERR and the interrupt line. When the mode bit of device/head is set, it also presents the 28-bit logical block address built from the address registers.

Top module: `ata_taskfile_regs`

## Requirements
- R1: After reset the status byte reads 0x50, INTRQ is low, and the sector count, sector number, cylinder and device/head registers read 0.
- R2: Writes at command-block offsets 2 to 6 (sector count, sector number, cylinder low, cylinder high, device/head) read back unchanged at the same offset on the next read, with bits 15:8 of the read data at 0.
- R3: Offset 0 of the command block is a 16-bit data port that returns the full 16-bit word last written.
- R4: A write at command-block offset 7 while not busy sets BSY. In the following cycle it pulses the engine command strobe, carrying the written opcode and the features byte last written at offset 1.
- R5: While BSY is 1, host writes to every command-block offset are ignored.
- R6: An engine ready pulse while busy clears BSY and sets DRQ in the same cycle.
- R7: An engine completion pulse clears BSY and DRQ, sets ERR to the engine error flag, loads the error register read at offset 1 (0 on success), and asserts INTRQ unless interrupts are disabled.
- R8: A completion with the error flag set loads the sector count register with the engine's count of sectors not yet transferred. A successful completion leaves it unchanged.
- R9: A read of status (command-block offset 7) deasserts INTRQ. A read of alternate status (control offset 6) returns the same byte and leaves INTRQ unchanged.
- R10: Status layout: bit 7 BSY, bit 6 ready (1), bit 5 zero, bit 4 seek complete (1), bit 3 DRQ, bits 2 and 1 always 0, bit 0 ERR.
- R11: When device/head bit 6 is 1, the LBA-mode output is 1 and the LBA output equals {device/head[3:0], cylinder high, cylinder low, sector number}.
- R12: Bit 1 of a write to the control offset disables interrupts; while it is set, a completion leaves INTRQ low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs_cmd | input | 1 | Selects the command block |
| host_cs_ctl | input | 1 | Selects the control block |
| host_addr | input | 3 | Register offset |
| host_rd | input | 1 | Read strobe, one cycle |
| host_wr | input | 1 | Write strobe, one cycle |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, registered, valid the cycle after the strobe |
| intrq | output | 1 | Interrupt request |
| eng_cmd_strobe | output | 1 | One-cycle pulse on an accepted command |
| eng_cmd_code | output | 8 | Last accepted opcode |
| eng_cmd_features | output | 8 | Features byte |
| eng_drq_ready | input | 1 | Engine ready for first data sector |
| eng_done | input | 1 | Engine command completion |
| eng_err | input | 1 | Completion ended in error |
| eng_err_code | input | 8 | Error code for the error register |
| eng_remaining | input | 8 | Sectors not transferred on error |
| lba_mode | output | 1 | Device/head bit 6 |
| lba | output | 28 | Assembled logical block address |

## Verification
The assertions assume that the host never raises read and write together and never selects both blocks at once. They also assume that engine pulses last one cycle, with the ready pulse issued only while a command is outstanding. The bench drives every strobe for exactly one clock from a task, one access at a time. It issues engine pulses only after a command has been accepted, so every stimulus stays within those assumptions.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  typedef enum logic [2:0] {
    OFS_DATA    = 3'd0,
    OFS_ERRFEAT = 3'd1,
    OFS_SECCNT  = 3'd2,
    OFS_SECNUM  = 3'd3,
    OFS_CYLLO   = 3'd4,
    OFS_CYLHI   = 3'd5,
    OFS_DEVHEAD = 3'd6,
    OFS_CMDSTAT = 3'd7
  } tf_ofs_e;

  localparam logic [2:0] CTL_OFS   = 3'd6;
  localparam int         NIEN_BIT  = 1;
  localparam int         LBA_BIT   = 6;

  // Status byte: BSY, ready, 0, seek complete, DRQ, 0, 0, ERR
  function automatic logic [7:0] pack_status(input logic bsy, input logic drq, input logic err);
    return {bsy, 1'b1, 1'b0, 1'b1, drq, 2'b00, err};
  endfunction

  function automatic logic [27:0] make_lba(input logic [7:0] dh, input logic [7:0] ch,
                                           input logic [7:0] cl, input logic [7:0] sn);
    return {dh[3:0], ch, cl, sn};
  endfunction
endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode #(
  parameter int ADDR_W = 3,
  localparam int NREG = 1 << ADDR_W
) (
  input  logic              cs_cmd,
  input  logic              cs_ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic [NREG-1:0]   wr_sel,
  output logic [NREG-1:0]   rd_sel,
  output logic              wr_ctl,
  output logic              rd_alt
);
  import ata_tf_pkg::*;

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign wr_sel[i] = cs_cmd && wr && (addr == ADDR_W'(i));
    assign rd_sel[i] = cs_cmd && rd && (addr == ADDR_W'(i));
  end

  assign wr_ctl = cs_ctl && wr && (addr == ADDR_W'(CTL_OFS));
  assign rd_alt = cs_ctl && rd && (addr == ADDR_W'(CTL_OFS));
endmodule

// File: rtl/ata_tf_status.sv
module ata_tf_status (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_accept,
  input  logic drq_ready,
  input  logic done,
  input  logic done_err,
  input  logic nien,
  input  logic status_rd,
  output logic bsy,
  output logic drq,
  output logic err,
  output logic intrq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bsy   <= 1'b0;
      drq   <= 1'b0;
      err   <= 1'b0;
      intrq <= 1'b0;
    end else begin
      if (done) begin
        bsy <= 1'b0;
        drq <= 1'b0;
        err <= done_err;
      end else if (cmd_accept) begin
        bsy <= 1'b1;
        drq <= 1'b0;
        err <= 1'b0;
      end else if (drq_ready && bsy) begin
        bsy <= 1'b0;
        drq <= 1'b1;
      end

      if (done && !nien)   intrq <= 1'b1;
      else if (cmd_accept) intrq <= 1'b0;
      else if (status_rd)  intrq <= 1'b0;
    end
  end
endmodule

// File: rtl/ata_tf_regfile.sv
module ata_tf_regfile #(
  parameter int REG_W  = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  localparam int NREG  = 1 << ADDR_W,
  localparam int LBA_W = 4 + 3 * REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREG-1:0]   wr_en,
  input  logic              wr_ctl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              done,
  input  logic              done_err,
  input  logic [REG_W-1:0]  err_code,
  input  logic [REG_W-1:0]  remaining,
  output logic [DATA_W-1:0] data_q,
  output logic [REG_W-1:0]  feat_q,
  output logic [REG_W-1:0]  errreg_q,
  output logic [REG_W-1:0]  sc_q,
  output logic [REG_W-1:0]  sn_q,
  output logic [REG_W-1:0]  cl_q,
  output logic [REG_W-1:0]  ch_q,
  output logic [REG_W-1:0]  dh_q,
  output logic [REG_W-1:0]  cmd_q,
  output logic              nien_q,
  output logic              lba_mode,
  output logic [LBA_W-1:0]  lba
);
  import ata_tf_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q   <= '0;
      feat_q   <= '0;
      errreg_q <= '0;
      sc_q     <= '0;
      sn_q     <= '0;
      cl_q     <= '0;
      ch_q     <= '0;
      dh_q     <= '0;
      cmd_q    <= '0;
      nien_q   <= 1'b0;
    end else begin
      if (wr_en[OFS_DATA])    data_q <= wdata;
      if (wr_en[OFS_ERRFEAT]) feat_q <= wdata[REG_W-1:0];
      if (wr_en[OFS_SECNUM])  sn_q   <= wdata[REG_W-1:0];
      if (wr_en[OFS_CYLLO])   cl_q   <= wdata[REG_W-1:0];
      if (wr_en[OFS_CYLHI])   ch_q   <= wdata[REG_W-1:0];
      if (wr_en[OFS_DEVHEAD]) dh_q   <= wdata[REG_W-1:0];
      if (wr_en[OFS_CMDSTAT]) cmd_q  <= wdata[REG_W-1:0];
      if (wr_ctl)             nien_q <= wdata[NIEN_BIT];

      if (done && done_err)       sc_q <= remaining;
      else if (wr_en[OFS_SECCNT]) sc_q <= wdata[REG_W-1:0];

      if (done) errreg_q <= done_err ? err_code : '0;
    end
  end

  assign lba_mode = dh_q[LBA_BIT];
  assign lba      = make_lba(dh_q, ch_q, cl_q, sn_q);
endmodule

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs #(
  parameter int REG_W  = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  localparam int NREG  = 1 << ADDR_W,
  localparam int LBA_W = 4 + 3 * REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs_cmd,
  input  logic              host_cs_ctl,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              intrq,
  output logic              eng_cmd_strobe,
  output logic [REG_W-1:0]  eng_cmd_code,
  output logic [REG_W-1:0]  eng_cmd_features,
  input  logic              eng_drq_ready,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic [REG_W-1:0]  eng_err_code,
  input  logic [REG_W-1:0]  eng_remaining,
  output logic              lba_mode,
  output logic [LBA_W-1:0]  lba
);
  import ata_tf_pkg::*;

  logic [NREG-1:0] wr_sel, rd_sel, wr_en;
  logic            wr_ctl, rd_alt;
  logic            bsy, drq, err, nien;
  logic            cmd_accept, status_rd_evt;
  logic [DATA_W-1:0] data_q;
  logic [REG_W-1:0]  feat_q, errreg_q, sc_q, sn_q, cl_q, ch_q, dh_q, cmd_q;
  logic [REG_W-1:0]  status_byte;
  logic [DATA_W-1:0] rd_next;

  ata_tf_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cs_cmd(host_cs_cmd), .cs_ctl(host_cs_ctl), .addr(host_addr),
    .rd(host_rd), .wr(host_wr),
    .wr_sel(wr_sel), .rd_sel(rd_sel), .wr_ctl(wr_ctl), .rd_alt(rd_alt)
  );

  assign wr_en         = bsy ? '0 : wr_sel;
  assign cmd_accept    = wr_en[OFS_CMDSTAT];
  assign status_rd_evt = rd_sel[OFS_CMDSTAT];

  ata_tf_status u_stat (
    .clk(clk), .rst_n(rst_n), .cmd_accept(cmd_accept), .drq_ready(eng_drq_ready),
    .done(eng_done), .done_err(eng_err), .nien(nien), .status_rd(status_rd_evt),
    .bsy(bsy), .drq(drq), .err(err), .intrq(intrq)
  );

  ata_tf_regfile #(.REG_W(REG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctl(wr_ctl), .wdata(host_wdata),
    .done(eng_done), .done_err(eng_err), .err_code(eng_err_code),
    .remaining(eng_remaining),
    .data_q(data_q), .feat_q(feat_q), .errreg_q(errreg_q), .sc_q(sc_q),
    .sn_q(sn_q), .cl_q(cl_q), .ch_q(ch_q), .dh_q(dh_q), .cmd_q(cmd_q),
    .nien_q(nien), .lba_mode(lba_mode), .lba(lba)
  );

  assign status_byte = pack_status(bsy, drq, err);

  always_comb begin
    rd_next = '0;
    if (rd_alt) rd_next = DATA_W'(status_byte);
    else if (host_cs_cmd) begin
      case (tf_ofs_e'(host_addr))
        OFS_DATA:    rd_next = data_q;
        OFS_ERRFEAT: rd_next = DATA_W'(errreg_q);
        OFS_SECCNT:  rd_next = DATA_W'(sc_q);
        OFS_SECNUM:  rd_next = DATA_W'(sn_q);
        OFS_CYLLO:   rd_next = DATA_W'(cl_q);
        OFS_CYLHI:   rd_next = DATA_W'(ch_q);
        OFS_DEVHEAD: rd_next = DATA_W'(dh_q);
        default:     rd_next = DATA_W'(status_byte);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata     <= '0;
      eng_cmd_strobe <= 1'b0;
    end else begin
      if (host_rd && (host_cs_cmd || rd_alt)) host_rdata <= rd_next;
      eng_cmd_strobe <= cmd_accept;
    end
  end

  assign eng_cmd_code     = cmd_q;
  assign eng_cmd_features = feat_q;
endmodule

// File: rtl/ata_tf_checker.sv
module ata_tf_checker #(
  parameter int DATA_W = 16,
  parameter int LBA_W  = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_accept,
  input logic              status_rd_evt,
  input logic              rd_alt,
  input logic              eng_done,
  input logic              eng_drq_ready,
  input logic              nien,
  input logic              bsy,
  input logic              drq,
  input logic              intrq,
  input logic              eng_cmd_strobe,
  input logic              host_wr,
  input logic              host_cs_cmd,
  input logic [DATA_W-1:0] host_rdata,
  input logic [LBA_W-1:0]  lba
);
  assert_cmd_sets_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept && !eng_done |=> bsy && eng_cmd_strobe);

  assert_busy_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bsy && host_wr && host_cs_cmd |=> $stable(lba));

  assert_ready_hands_drq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_drq_ready && bsy && !eng_done |=> !bsy && drq);

  assert_done_clears_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> !bsy && !drq);

  assert_status_read_acks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd_evt && !eng_done |=> !intrq);

  assert_alt_read_keeps_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_alt && !eng_done && !cmd_accept |=> $stable(intrq));

  assert_status_zero_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd_evt || rd_alt |=> host_rdata[5] == 1'b0 && host_rdata[2:1] == 2'b00);

  assert_masked_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done && nien && !intrq |=> !intrq);
endmodule

bind ata_taskfile_regs ata_tf_checker #(.DATA_W(DATA_W), .LBA_W(LBA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_accept(cmd_accept), .status_rd_evt(status_rd_evt),
  .rd_alt(rd_alt), .eng_done(eng_done), .eng_drq_ready(eng_drq_ready), .nien(nien),
  .bsy(bsy), .drq(drq), .intrq(intrq), .eng_cmd_strobe(eng_cmd_strobe),
  .host_wr(host_wr), .host_cs_cmd(host_cs_cmd), .host_rdata(host_rdata), .lba(lba)
);

// File: tb/test_ata_taskfile_regs.sv
module test_ata_taskfile_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_cmd = 0, cs_ctl = 0, rd = 0, wr = 0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        intrq, cmd_stb, lba_mode;
  logic [7:0]  cmd_code, cmd_feat;
  logic        drq_ready = 0, done = 0, e_err = 0;
  logic [7:0]  e_code = '0, e_rem = '0;
  logic [27:0] lba;

  int checks = 0, fails = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  bit          finished = 0;

  always #2 clk = ~clk;

  ata_taskfile_regs i_ata_taskfile_regs (
    .clk(clk), .rst_n(rst_n), .host_cs_cmd(cs_cmd), .host_cs_ctl(cs_ctl),
    .host_addr(addr), .host_rd(rd), .host_wr(wr), .host_wdata(wdata),
    .host_rdata(rdata), .intrq(intrq), .eng_cmd_strobe(cmd_stb),
    .eng_cmd_code(cmd_code), .eng_cmd_features(cmd_feat),
    .eng_drq_ready(drq_ready), .eng_done(done), .eng_err(e_err),
    .eng_err_code(e_code), .eng_remaining(e_rem), .lba_mode(lba_mode), .lba(lba)
  );

  // Expected status byte restated from R10
  function automatic logic [15:0] stat(bit b, bit d, bit e);
    return 16'h0050 | (b ? 16'h80 : 0) | (d ? 16'h08 : 0) | (e ? 16'h01 : 0);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every read strobe
  always @(posedge clk) begin
    if (rd) begin
      #1;
      if (exp_q.size() == 0) check("scoreboard", 1, 0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic host_write(bit ctl, logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    cs_cmd = !ctl; cs_ctl = ctl; addr = a; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0; cs_cmd = 0; cs_ctl = 0;
  endtask

  task automatic host_read(bit ctl, logic [2:0] a, logic [15:0] exp, string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    cs_cmd = !ctl; cs_ctl = ctl; addr = a; rd = 1;
    @(negedge clk);
    rd = 0; cs_cmd = 0; cs_ctl = 0;
  endtask

  task automatic eng_ready();
    @(negedge clk); drq_ready = 1;
    @(negedge clk); drq_ready = 0;
  endtask

  task automatic eng_finish(bit e, logic [7:0] code, logic [7:0] rem);
    @(negedge clk); done = 1; e_err = e; e_code = code; e_rem = rem;
    @(negedge clk); done = 0; e_err = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 intrq", intrq, 0);
    host_read(0, 7, stat(0,0,0), "R1 status");
    host_read(0, 2, 16'h0000, "R1 seccnt");
    host_read(0, 6, 16'h0000, "R1 devhead");
    // R2 readback, R11 LBA
    host_write(0, 2, 16'hAB05);
    host_write(0, 3, 16'h0011);
    host_write(0, 4, 16'h0022);
    host_write(0, 5, 16'h0033);
    host_write(0, 6, 16'h00E7);
    host_read(0, 2, 16'h0005, "R2 seccnt");
    host_read(0, 3, 16'h0011, "R2 secnum");
    host_read(0, 4, 16'h0022, "R2 cyllo");
    host_read(0, 5, 16'h0033, "R2 cylhi");
    host_read(0, 6, 16'h00E7, "R2 devhead");
    check("R11 lba_mode", lba_mode, 1);
    check("R11 lba", lba, 28'h7332211);
    host_write(0, 6, 16'h00A7);
    check("R11 chs mode", lba_mode, 0);
    // R3 data port
    host_write(0, 0, 16'hBEEF);
    host_read(0, 0, 16'hBEEF, "R3 data");
    host_write(0, 0, 16'h1234);
    host_read(0, 0, 16'h1234, "R3 data 2");
    // R4 command
    host_write(0, 1, 16'h0003);
    host_write(0, 7, 16'h0020);
    check("R4 strobe", cmd_stb, 1);
    check("R4 code", cmd_code, 8'h20);
    check("R4 features", cmd_feat, 8'h03);
    @(negedge clk);
    check("R4 strobe one cycle", cmd_stb, 0);
    host_read(1, 6, stat(1,0,0), "R4 R10 alt busy");
    // R5 writes ignored while busy
    host_write(0, 2, 16'h0099);
    host_write(0, 3, 16'h0077);
    host_write(0, 7, 16'h0030);
    check("R5 no strobe", cmd_stb, 0);
    host_read(0, 2, 16'h0005, "R5 seccnt kept");
    host_read(0, 3, 16'h0011, "R5 secnum kept");
    // R6 ready
    eng_ready();
    host_read(0, 7, stat(0,1,0), "R6 status drq");
    // R7/R8 error completion
    eng_finish(1, 8'h10, 8'h03);
    check("R7 intrq set", intrq, 1);
    host_read(1, 6, stat(0,0,1), "R9 alt status");
    check("R9 alt keeps intrq", intrq, 1);
    host_read(0, 1, 16'h0010, "R7 error reg");
    host_read(0, 2, 16'h0003, "R8 remaining");
    host_read(0, 7, stat(0,0,1), "R9 status");
    check("R9 status acks intrq", intrq, 0);
    // R12 nIEN masks interrupt
    host_write(1, 6, 16'h0002);
    host_write(0, 7, 16'h0030);
    eng_finish(0, 8'h55, 8'h09);
    check("R12 masked intrq", intrq, 0);
    host_read(0, 7, stat(0,0,0), "R7 err cleared");
    host_read(0, 1, 16'h0000, "R7 error reg cleared");
    host_read(0, 2, 16'h0003, "R8 success keeps seccnt");
    // R7 unmasked success
    host_write(1, 6, 16'h0000);
    host_write(0, 7, 16'h0040);
    eng_finish(0, 8'h00, 8'h00);
    check("R7 intrq on success", intrq, 1);
    host_read(0, 7, stat(0,0,0), "R9 status 2");
    check("R9 ack 2", intrq, 0);
    repeat (3) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule